// File: doc/BRIEF.md
# Bulk Register Save/Restore Engine

This block holds a 64-entry register file whose four physical ports can be handed between the instruction pipeline and a built-in bulk mover. While the mover is idle, the pipeline gets three combinational read ports and one write port. A command names a start register, a count, a base byte address and a direction.

A save takes all four ports as readers. It streams groups of four consecutive registers to a memory-write stream, and each group carries a lane mask so that a final group can be partial. A restore takes all four ports as writers. It marks every register in the set busy in one cycle and then writes returning groups from a memory-read stream. Each register's busy bit is released as its own data lands. Registers are always visited upward from the start register, wrapping from 63 to 0. Code that resumes after a restore can therefore use the earliest registers while later ones are still in flight. A pipeline read of a busy register reports a stall rather than stale data.

A save can be launched while the new context's first instruction and first data are still being fetched, so that the save stream overlaps that wait.

Top module: `rf_bulk_mover`

## Requirements
- R1: Each of the three pipeline read ports returns, combinationally, the current contents of the register it names. A write accepted at a clock edge is visible from that edge onward.
- R2: `wrAccept` is high only while the engine is idle. A write presented during a save or a restore is refused and leaves the file unchanged.
- R3: A save of N registers from S to base B gives ceil(N/4) beats. Beat k has lane l (bits 32l+31..32l) holding register (S+4k+l) mod 64, `saveMask` bit l set for the first min(4, N-4k) lanes, unmasked lanes zero, and `memAddr` = B+16k. A beat stays unchanged until `saveValid && saveReady`. A pipeline write taken in the same cycle as the save command is included in the stream.
- R4: While a save is in progress, every pipeline read port reports a stall.
- R5: In the cycle after a restore command is accepted, every register in the set reads as stalled.
- R6: During a restore, `memAddr` gives the byte address of the next expected group (B+16k). Each beat taken with `rstrValid && rstrReady` writes that group's lanes and clears their busy bits from the next cycle. A register stays stalled until its own beat lands, and registers outside the set stay readable throughout.
- R7: `done` pulses for exactly one cycle, the cycle after the final beat's handshake. In that same cycle `cmdReady` is high again.
- R8: A command is taken only when `cmdValid` and `cmdReady` are both high. A command presented while busy has no effect.
- R9: A count of 0 moves nothing and pulses `done` in the next cycle. Counts above 64 are treated as 64.
- R10: After reset the engine is idle: `cmdReady` high, no stream valid, `done` low, and no register busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdIdx | input | 18 | Three 6-bit read register indices, port p at bits 6p+5..6p |
| rdData | output | 96 | Three 32-bit read results, port p at bits 32p+31..32p |
| rdStall | output | 3 | Per-port stall: register busy or save in progress |
| wrEn | input | 1 | Pipeline write request |
| wrIdx | input | 6 | Pipeline write register |
| wrData | input | 32 | Pipeline write value |
| wrAccept | output | 1 | Write is taken this cycle |
| cmdValid | input | 1 | Bulk command offered |
| cmdReady | output | 1 | Engine idle, command can be taken |
| cmdSave | input | 1 | 1 = save, 0 = restore |
| cmdStart | input | 6 | First register of the set |
| cmdCount | input | 7 | Number of registers (0..127, clamped to 64) |
| cmdAddr | input | 32 | Base byte address |
| memAddr | output | 32 | Byte address of the current group |
| saveValid | output | 1 | Save beat valid |
| saveReady | input | 1 | Memory accepts save beat |
| saveData | output | 128 | Four register lanes |
| saveMask | output | 4 | Valid lanes of the save beat |
| rstrValid | input | 1 | Restore beat valid |
| rstrReady | output | 1 | Engine accepts restore beat |
| rstrData | input | 128 | Four returning register lanes |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two kinds of operation can fall in the same cycle. The first is a restore beat landing while the pipeline reads a register of that beat. The bench holds a read port on the first register of the expected group and offers the beat. It expects a stall in the landing cycle and the new value with no stall from the next cycle. The second is a pipeline write taken in the same cycle as a save command. The bench writes the start register together with the command and expects the new value in lane 0 of the first beat. Stream readiness and validity are randomised from a fixed seed, so beats are both stalled and taken back to back.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  localparam int IDX_W = 6;
  localparam int LANES = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_SAVE, ST_LOAD} mode_t;

  typedef struct packed {
    logic             saving;
    logic             restoring;
    logic             markBusy;
    logic             landBeat;
    logic [IDX_W-1:0] groupBase;
    logic [LANES-1:0] laneMask;
    logic [IDX_W-1:0] setStart;
    logic [IDX_W:0]   setCount;
  } ctlStrobe_t;
endpackage

// File: rtl/rf_bulk_ctl.sv
module rf_bulk_ctl
  import rfb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdSave,
  input  logic [IDX_W-1:0]  cmdStart,
  input  logic [IDX_W:0]    cmdCount,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              saveReady,
  input  logic              rstrValid,
  output logic              cmdReady,
  output logic              done,
  output logic [ADDR_W-1:0] memAddr,
  output ctlStrobe_t        strobe
);
  localparam int NUM_REGS = 1 << IDX_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(LANES * DATA_W / 8);
  localparam logic [IDX_W:0] MAX_CNT = (IDX_W+1)'(NUM_REGS);
  localparam logic [IDX_W:0] LANE_CNT = (IDX_W+1)'(LANES);

  mode_t             mode;
  logic [IDX_W-1:0]  grpBase;
  logic [IDX_W:0]    remain;
  logic [ADDR_W-1:0] addrQ;
  logic              doneQ;
  logic [IDX_W:0]    effCount;
  logic [LANES-1:0]  laneMask;
  logic              takeBeat;
  logic              lastBeat;

  always_comb begin
    effCount = (cmdCount > MAX_CNT) ? MAX_CNT : cmdCount;
    for (int l = 0; l < LANES; l++) laneMask[l] = (remain > (IDX_W+1)'(l));
    takeBeat = ((mode == ST_SAVE) && saveReady) || ((mode == ST_LOAD) && rstrValid);
    lastBeat = (remain <= LANE_CNT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode    <= ST_IDLE;
      grpBase <= '0;
      remain  <= '0;
      addrQ   <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (mode == ST_IDLE) begin
        if (cmdValid) begin
          if (effCount == '0) begin
            doneQ <= 1'b1;
          end else begin
            mode    <= cmdSave ? ST_SAVE : ST_LOAD;
            grpBase <= cmdStart;
            remain  <= effCount;
            addrQ   <= cmdAddr;
          end
        end
      end else if (takeBeat) begin
        grpBase <= grpBase + IDX_W'(LANES);
        addrQ   <= addrQ + STEP;
        if (lastBeat) begin
          mode   <= ST_IDLE;
          remain <= '0;
          doneQ  <= 1'b1;
        end else begin
          remain <= remain - LANE_CNT;
        end
      end
    end
  end

  always_comb begin
    strobe.saving    = (mode == ST_SAVE);
    strobe.restoring = (mode == ST_LOAD);
    strobe.markBusy  = (mode == ST_IDLE) && cmdValid && !cmdSave && (effCount != '0);
    strobe.landBeat  = (mode == ST_LOAD) && rstrValid;
    strobe.groupBase = grpBase;
    strobe.laneMask  = laneMask;
    strobe.setStart  = cmdStart;
    strobe.setCount  = effCount;
  end

  assign cmdReady = (mode == ST_IDLE);
  assign done     = doneQ;
  assign memAddr  = addrQ;
endmodule

// File: rtl/rf_bulk_dp.sv
module rf_bulk_dp
  import rfb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_RD = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobe_t                strobe,
  input  logic [NUM_RD*IDX_W-1:0]   rdIdx,
  output logic [NUM_RD*DATA_W-1:0]  rdData,
  output logic [NUM_RD-1:0]         rdStall,
  input  logic                      wrEn,
  input  logic [IDX_W-1:0]          wrIdx,
  input  logic [DATA_W-1:0]         wrData,
  output logic                      wrAccept,
  input  logic [LANES*DATA_W-1:0]   rstrData,
  output logic [LANES*DATA_W-1:0]   saveData
);
  localparam int NUM_REGS = 1 << IDX_W;

  logic [DATA_W-1:0]   regFile [NUM_REGS];
  logic [NUM_REGS-1:0] busy;

  assign wrAccept = !strobe.saving && !strobe.restoring;

  always_ff @(posedge clk) begin
    if (strobe.landBeat) begin
      for (int l = 0; l < LANES; l++)
        if (strobe.laneMask[l])
          regFile[strobe.groupBase + IDX_W'(l)] <= rstrData[l*DATA_W +: DATA_W];
    end else if (wrEn && wrAccept) begin
      regFile[wrIdx] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= '0;
    end else begin
      if (strobe.markBusy)
        for (int r = 0; r < NUM_REGS; r++)
          if ({1'b0, IDX_W'(r) - strobe.setStart} < strobe.setCount) busy[r] <= 1'b1;
      if (strobe.landBeat)
        for (int l = 0; l < LANES; l++)
          if (strobe.laneMask[l]) busy[strobe.groupBase + IDX_W'(l)] <= 1'b0;
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic [IDX_W-1:0] idx;
    assign idx = rdIdx[p*IDX_W +: IDX_W];
    assign rdData[p*DATA_W +: DATA_W] = regFile[idx];
    assign rdStall[p] = strobe.saving || busy[idx];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign saveData[l*DATA_W +: DATA_W] =
      strobe.laneMask[l] ? regFile[strobe.groupBase + IDX_W'(l)] : '0;
  end
endmodule

// File: rtl/rf_bulk_mover.sv
module rf_bulk_mover
  import rfb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [(LANES-1)*IDX_W-1:0]  rdIdx,
  output logic [(LANES-1)*DATA_W-1:0] rdData,
  output logic [LANES-2:0]            rdStall,
  input  logic                       wrEn,
  input  logic [IDX_W-1:0]           wrIdx,
  input  logic [DATA_W-1:0]          wrData,
  output logic                       wrAccept,
  input  logic                       cmdValid,
  output logic                       cmdReady,
  input  logic                       cmdSave,
  input  logic [IDX_W-1:0]           cmdStart,
  input  logic [IDX_W:0]             cmdCount,
  input  logic [ADDR_W-1:0]          cmdAddr,
  output logic [ADDR_W-1:0]          memAddr,
  output logic                       saveValid,
  input  logic                       saveReady,
  output logic [LANES*DATA_W-1:0]    saveData,
  output logic [LANES-1:0]           saveMask,
  input  logic                       rstrValid,
  output logic                       rstrReady,
  input  logic [LANES*DATA_W-1:0]    rstrData,
  output logic                       done
);
  localparam int NUM_RD = LANES - 1;

  ctlStrobe_t strobe;

  rf_bulk_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdSave(cmdSave),
    .cmdStart(cmdStart), .cmdCount(cmdCount), .cmdAddr(cmdAddr),
    .saveReady(saveReady), .rstrValid(rstrValid), .cmdReady(cmdReady),
    .done(done), .memAddr(memAddr), .strobe(strobe)
  );

  rf_bulk_dp #(.DATA_W(DATA_W), .NUM_RD(NUM_RD)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdIdx(rdIdx), .rdData(rdData),
    .rdStall(rdStall), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .wrAccept(wrAccept), .rstrData(rstrData), .saveData(saveData)
  );

  assign saveValid = strobe.saving;
  assign rstrReady = strobe.restoring;
  assign saveMask  = strobe.saving ? strobe.laneMask : '0;
endmodule

// File: rtl/rf_bulk_mover_chk.sv
module rf_bulk_mover_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    cmdValid,
  input logic                    cmdReady,
  input logic                    done,
  input logic                    saveValid,
  input logic                    saveReady,
  input logic [4*DATA_W-1:0]     saveData,
  input logic [3:0]              saveMask,
  input logic [ADDR_W-1:0]       memAddr,
  input logic                    rstrReady,
  input logic                    wrAccept,
  input logic [2:0]              rdStall
);
  assert_write_refused_R2: assert property (@(posedge clk) disable iff (!rstN)
    (saveValid || rstrReady) |-> !wrAccept);

  assert_beat_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (saveValid && !saveReady) |=> (saveValid && $stable(saveData) && $stable(saveMask) && $stable(memAddr)));

  assert_mask_shape_R3: assert property (@(posedge clk) disable iff (!rstN)
    saveValid |-> (saveMask[0] && ((saveMask & (saveMask + 4'd1)) == 4'd0)));

  assert_reads_stall_R4: assert property (@(posedge clk) disable iff (!rstN)
    saveValid |-> (&rdStall));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> cmdReady);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !cmdValid) |=> !done);

  assert_single_owner_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(saveValid && rstrReady));

  assert_idle_no_stream_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (!saveValid && !rstrReady));
endmodule

bind rf_bulk_mover rf_bulk_mover_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady), .done(done),
  .saveValid(saveValid), .saveReady(saveReady), .saveData(saveData),
  .saveMask(saveMask), .memAddr(memAddr), .rstrReady(rstrReady),
  .wrAccept(wrAccept), .rdStall(rdStall)
);

// File: tb/sim_rf_bulk_mover.sv
`timescale 1ns/1ps
module sim_rf_bulk_mover;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [17:0]  rdIdx = '0;
  logic [95:0]  rdData;
  logic [2:0]   rdStall;
  logic         wrEn = 1'b0;
  logic [5:0]   wrIdx = '0;
  logic [31:0]  wrData = '0;
  logic         wrAccept;
  logic         cmdValid = 1'b0;
  logic         cmdReady;
  logic         cmdSave = 1'b0;
  logic [5:0]   cmdStart = '0;
  logic [6:0]   cmdCount = '0;
  logic [31:0]  cmdAddr = '0;
  logic [31:0]  memAddr;
  logic         saveValid;
  logic         saveReady = 1'b0;
  logic [127:0] saveData;
  logic [3:0]   saveMask;
  logic         rstrValid = 1'b0;
  logic         rstrReady;
  logic [127:0] rstrData = '0;
  logic         done;

  rf_bulk_mover u0 (.*);

  int checks = 0;
  int errors = 0;
  logic [31:0] model [64];

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] rdOut(input int p);
    return rdData[p*32 +: 32];
  endfunction

  task automatic setRd(input int a, input int b, input int c);
    rdIdx = {6'(c), 6'(b), 6'(a)};
  endtask

  task automatic writeReg(input int idx, input logic [31:0] val);
    wrEn = 1'b1; wrIdx = 6'(idx); wrData = val;
    #1;
    check(wrAccept, "R2 idle write accepted", wrAccept, 1);
    step();
    wrEn = 1'b0;
    model[idx] = val;
  endtask

  task automatic readCheck(input int a, input int b, input int c, input string req);
    setRd(a, b, c);
    #1;
    for (int p = 0; p < 3; p++) begin
      int idx;
      idx = (p == 0) ? a : (p == 1) ? b : c;
      check(rdOut(p) == model[idx] && !rdStall[p], req, {rdStall[p], rdOut(p)}, {1'b0, model[idx]});
    end
  endtask

  task automatic verifyAll(input string req);
    for (int i = 0; i < 64; i += 3) begin
      readCheck(i, (i + 1) % 64, (i + 2) % 64, req);
      step();
    end
  endtask

  task automatic runSave(input int s, input int n, input logic [31:0] base, input bit clash);
    int eff, beats, k;
    logic [31:0] nv;
    eff = (n > 64) ? 64 : n;
    beats = (eff + 3) / 4;
    cmdValid = 1'b1; cmdSave = 1'b1; cmdStart = 6'(s); cmdCount = 7'(n); cmdAddr = base;
    nv = $urandom;
    if (clash) begin wrEn = 1'b1; wrIdx = 6'(s); wrData = nv; end
    #1;
    check(cmdReady, "R8 ready when idle", cmdReady, 1);
    step();
    cmdValid = 1'b0;
    if (clash) begin wrEn = 1'b0; model[s] = nv; end
    if (eff == 0) begin
      #1;
      check(done && !saveValid, "R9 zero count save", {saveValid, done}, 2'b01);
      return;
    end
    k = 0;
    while (k < beats) begin
      int lanes;
      logic [127:0] expD;
      logic [3:0] expM;
      lanes = (eff - 4*k > 4) ? 4 : eff - 4*k;
      expD = '0; expM = '0;
      for (int l = 0; l < lanes; l++) begin
        expD[l*32 +: 32] = model[(s + 4*k + l) % 64];
        expM[l] = 1'b1;
      end
      saveReady = ($urandom % 3) != 0;
      wrEn = 1'b1; wrIdx = 6'($urandom); wrData = $urandom;
      cmdValid = (k == 0); cmdSave = 1'b0;
      #1;
      check(saveValid && saveMask == expM, "R3 beat valid and mask", {saveValid, saveMask}, {1'b1, expM});
      check(saveData == expD, "R3 beat data", saveData, expD);
      check(memAddr == base + 32'(16*k), "R3 beat address", memAddr, base + 32'(16*k));
      check(!wrAccept, "R2 write refused during save", wrAccept, 0);
      check(rdStall == 3'b111, "R4 reads stall during save", rdStall, 3'b111);
      if (k == 0) check(!cmdReady, "R8 command refused while busy", cmdReady, 0);
      step();
      wrEn = 1'b0; cmdValid = 1'b0;
      if (saveReady) k++;
    end
    saveReady = 1'b0;
    #1;
    check(done && cmdReady && !rstrReady, "R7 done after last save beat", {rstrReady, cmdReady, done}, 3'b011);
    step();
    check(!done, "R7 done lasts one cycle", done, 0);
  endtask

  task automatic runRestore(input int s, input int n, input logic [31:0] base);
    int eff, beats, k, outside;
    eff = (n > 64) ? 64 : n;
    beats = (eff + 3) / 4;
    cmdValid = 1'b1; cmdSave = 1'b0; cmdStart = 6'(s); cmdCount = 7'(n); cmdAddr = base;
    #1;
    check(cmdReady, "R8 ready when idle", cmdReady, 1);
    step();
    cmdValid = 1'b0;
    if (eff == 0) begin
      #1;
      check(done && !rstrReady, "R9 zero count restore", {rstrReady, done}, 2'b01);
      return;
    end
    outside = (s + eff) % 64;
    setRd(s, outside, s);
    wrEn = 1'b1; wrIdx = 6'(outside); wrData = ~model[outside];
    #1;
    check(rdStall[0], "R5 set busy after restore start", rdStall[0], 1);
    if (eff < 64)
      check(!rdStall[1] && rdOut(1) == model[outside], "R6 register outside set readable",
            {rdStall[1], rdOut(1)}, {1'b0, model[outside]});
    check(!wrAccept, "R2 write refused during restore", wrAccept, 0);
    k = 0;
    while (k < beats) begin
      int lanes;
      lanes = (eff - 4*k > 4) ? 4 : eff - 4*k;
      rstrValid = ($urandom % 3) != 0;
      rstrData = {$urandom, $urandom, $urandom, $urandom};
      setRd(s, (s + eff - 1) % 64, (s + 4*k) % 64);
      #1;
      check(rstrReady && memAddr == base + 32'(16*k), "R6 expected group address",
            {rstrReady, memAddr}, {1'b1, base + 32'(16*k)});
      check(rdStall[2], "R6 register stalls in its landing cycle", rdStall[2], 1);
      step();
      if (rstrValid) begin
        for (int l = 0; l < lanes; l++) model[(s + 4*k + l) % 64] = rstrData[l*32 +: 32];
        k++;
        #1;
        check(!rdStall[2] && rdOut(2) == model[(s + 4*(k-1)) % 64], "R6 landed register readable",
              {rdStall[2], rdOut(2)}, {1'b0, model[(s + 4*(k-1)) % 64]});
        if (k < beats) check(rdStall[1], "R6 later register still busy", rdStall[1], 1);
      end
    end
    rstrValid = 1'b0; wrEn = 1'b0;
    check(done && cmdReady, "R7 done after last restore beat", {cmdReady, done}, 2'b11);
    step();
    check(!done, "R7 done lasts one cycle", done, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    setRd(0, 1, 2);
    #1;
    check(cmdReady && !saveValid && !rstrReady && !done, "R10 idle after reset",
          {cmdReady, saveValid, rstrReady, done}, 4'b1000);
    check(rdStall == 3'b000, "R10 nothing busy after reset", rdStall, 0);
    step();
    for (int i = 0; i < 64; i++) writeReg(i, $urandom);
    verifyAll("R1 read after write");
    runSave(62, 7, 32'h0000_1000, 1'b1);
    runSave(10, 0, 32'h0000_1800, 1'b0);
    step();
    runSave(0, 100, 32'h0000_2000, 1'b0);
    verifyAll("R2 refused writes left file unchanged");
    runRestore(60, 10, 32'h0000_3000);
    verifyAll("R6 restored contents");
    runRestore(5, 64, 32'h0000_4000);
    verifyAll("R6 full restore contents");
    runRestore(0, 0, 32'h0000_5000);
    step();
    for (int it = 0; it < 10; it++) begin
      int s, n;
      s = $urandom % 64;
      n = $urandom % 70;
      if ($urandom % 2) runSave(s, n, 32'($urandom) & 32'hFFFF_FFF0, 1'b1);
      else runRestore(s, n, 32'($urandom) & 32'hFFFF_FFF0);
      step();
      verifyAll("R1 readback after random bulk op");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule